// File: doc/BRIEF.md
# Programmable Master Clock Divider

This block turns a free-running master oscillator clock into a slower system rate for a small processor core and its peripherals. It does not make a new clock. It drives a clock-enable strobe that is one master cycle wide, in the master clock domain. Every register downstream qualifies its updates with this strobe, so the whole system slows down together. The strobe never glitches and adds no skew to the clock tree.

Firmware controls the rate through one 8-bit control register:
- Bit 7 turns division on.
- Bits 6..0 hold a divide code `d`. While division is on, the strobe fires once every `129 - d` master cycles.
- While division is off, the strobe is high on every cycle, so the system runs at the full master rate.

The code is protected by a write-lock rule. A new code is accepted only by the write that switches division from off to on. Every other write leaves the stored code alone. The divide factor therefore cannot change while the divider is running.

Top module: `mclk_divider`

## Requirements
- R1: After reset, `rd_data` reads 0x00 and `clk_en_o` is high on every cycle, because division starts disabled.
- R2: `rd_data` always returns the stored enable in bit 7 and the stored 7-bit divide code in bits 6..0.
- R3: A write (`wr_en` high) with bit 7 set, made while the stored enable is 0, sets the enable and stores `wr_data[6:0]` as the new code.
- R4: A write with bit 7 set, made while the stored enable is already 1, leaves both the enable and the stored code unchanged and does not restart the divide sequence.
- R5: A write with bit 7 clear clears the enable and discards `wr_data[6:0]`, so the stored code keeps its old value.
- R6: While the stored enable is 0, `clk_en_o` is high on every cycle, starting with the cycle after a disabling write.
- R7: While the stored enable is 1 with code `d`, `clk_en_o` is high on exactly one cycle out of every `129 - d`. This gives 129 for `d = 0`, 2 for `d = 127`, and 3 for `d = 126`.
- R8: After an enabling write in cycle 0, the first high cycle of `clk_en_o` is cycle `129 - d`, and `clk_en_o` is low in cycles 1 to `128 - d`.
- R9: When `wr_en` is low, `wr_data` has no effect on the stored register or on `clk_en_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Write data: bit 7 is the enable, bits 6..0 are the divide code |
| rd_data | output | 8 | Read-back of the stored enable and divide code |
| clk_en_o | output | 1 | Clock-enable strobe for the core and its peripherals |

## Verification
The bench measures the strobe cycle by cycle after each enabling write. A counter with an off-by-one error in its load value would put the first pulse one cycle early or late, and the bench catches that at both ends of the code range (periods 129 and 2) as well as in the middle. It rewrites the code while the divider is running, and issues a disabling write that carries a non-zero code. A design that ignored the write-lock would then read back the wrong code, or change the pulse rate without first passing through the disabled state. It also checks that the strobe goes high on the cycle right after a disabling write, and that data presented with the write strobe low changes nothing.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // Default width of the divide code field
  localparam int unsigned DEF_CODE_W = 7;

  // Classification of one control-register write
  typedef enum logic [1:0] {
    WR_IDLE   = 2'd0,  // no write this cycle
    WR_ARM    = 2'd1,  // enable goes 0 -> 1, code is taken
    WR_KEEP   = 2'd2,  // enable stays 1, code is refused
    WR_DISARM = 2'd3   // enable cleared, code is refused
  } wr_act_e;

endpackage

// File: rtl/clkdiv_rst_sync.sv
module clkdiv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  // Assert asynchronously, release through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/clkdiv_ctrl_reg.sv
module clkdiv_ctrl_reg #(
  parameter int unsigned CODE_W = clkdiv_pkg::DEF_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W:0]   wr_data,
  output logic              en_o,
  output logic [CODE_W-1:0] code_o,
  output logic              arm_o
);
  import clkdiv_pkg::*;

  logic              en_q,   en_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              en_ce,  code_ce;
  wr_act_e           act;

  // Classify the write against the stored enable
  always_comb begin
    if (!wr_en) begin
      act = WR_IDLE;
    end else if (!wr_data[CODE_W]) begin
      act = WR_DISARM;
    end else if (!en_q) begin
      act = WR_ARM;
    end else begin
      act = WR_KEEP;
    end
  end

  // Next state and clock enables
  always_comb begin
    en_d    = en_q;
    code_d  = code_q;
    en_ce   = 1'b0;
    code_ce = 1'b0;
    unique case (act)
      WR_ARM: begin
        en_d    = 1'b1;
        code_d  = wr_data[CODE_W-1:0];
        en_ce   = 1'b1;
        code_ce = 1'b1;
      end
      WR_DISARM: begin
        en_d  = 1'b0;
        en_ce = 1'b1;
      end
      default: begin
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (en_ce) begin
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (code_ce) begin
      code_q <= code_d;
    end
  end

  assign en_o   = en_q;
  assign code_o = code_q;
  assign arm_o  = (act == WR_ARM);

  // R3
  arm_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[CODE_W] && !en_q) |=>
      (en_q && code_q == $past(wr_data[CODE_W-1:0])));

  // R4
  code_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_data[CODE_W] && !en_q) |=> $stable(code_q));

  // R5
  disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[CODE_W]) |=> !en_q);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(en_q) && $stable(code_q)));

endmodule

// File: rtl/clkdiv_pulse_ctr.sv
module clkdiv_pulse_ctr #(
  parameter int unsigned CODE_W = clkdiv_pkg::DEF_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              load_i,
  input  logic [CODE_W-1:0] load_code_i,
  output logic              pulse_o
);

  // Divisor is (2**CODE_W + 1) - code; the counter runs from divisor-1 down to 0
  localparam int unsigned DIV_MAX = (1 << CODE_W) + 1;
  localparam int unsigned CNT_W   = $clog2(DIV_MAX + 1);
  localparam logic [CNT_W-1:0] TOP_M1 = CNT_W'(DIV_MAX - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] run_m1, load_m1;
  logic             at_zero;

  assign run_m1  = TOP_M1 - CNT_W'(code_i);
  assign load_m1 = TOP_M1 - CNT_W'(load_code_i);
  assign at_zero = (cnt_q == '0);

  always_comb begin
    if (load_i) begin
      cnt_d = load_m1;
    end else if (!en_i) begin
      cnt_d = '0;
    end else if (at_zero) begin
      cnt_d = run_m1;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign pulse_o = !en_i || at_zero;

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_m1)));

  // R7
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && at_zero && !load_i) |=> (cnt_q == $past(run_m1)));

  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> (cnt_q <= run_m1));

endmodule

// File: rtl/mclk_divider.sv
module mclk_divider #(
  parameter int unsigned CODE_W = clkdiv_pkg::DEF_CODE_W,
  localparam int unsigned REG_W = CODE_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             clk_en_o
);

  logic              rst_sync_n;
  logic              en;
  logic [CODE_W-1:0] code;
  logic              arm;

  clkdiv_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  clkdiv_ctrl_reg #(.CODE_W(CODE_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .en_o    (en),
    .code_o  (code),
    .arm_o   (arm)
  );

  clkdiv_pulse_ctr #(.CODE_W(CODE_W)) u_ctr (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .en_i        (en),
    .code_i      (code),
    .load_i      (arm),
    .load_code_i (wr_data[CODE_W-1:0]),
    .pulse_o     (clk_en_o)
  );

  assign rd_data = {en, code};

  // R6
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && !wr_data[CODE_W]) |=> clk_en_o);

  // R8
  first_gap_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    arm |=> !clk_en_o);

endmodule

// File: tb/mclk_divider_tb_top.sv
module mclk_divider_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       clk_en_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  mclk_divider dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .clk_en_o (clk_en_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // One write cycle; returns at the negedge of the first cycle after it
  task automatic reg_write(input logic [7:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = 8'h5A;
  endtask

  task automatic t_reset();
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 rd_data", rd_data, 0);
    for (int i = 0; i < 3; i++) begin
      check("R1 clk_en_o", clk_en_o, 1);
      @(negedge clk);
    end
  endtask

  // Enable with code d, then follow three full periods cycle by cycle
  task automatic t_enable(input int d);
    int n;
    n = 129 - d;
    reg_write(8'h80 | 8'(d));
    check("R2/R3 rd_data", rd_data, 128 + d);
    for (int k = 1; k <= 3 * n; k++) begin
      check((k < n) ? "R8 first gap" : "R7 period", clk_en_o, (k % n == 0) ? 1 : 0);
      @(negedge clk);
    end
  endtask

  // Disabling write with a nonzero code; stored code must survive
  task automatic t_disable(input int old_code);
    reg_write(8'h21);
    check("R5 rd_data", rd_data, old_code);
    for (int i = 0; i < 5; i++) begin
      check("R6 clk_en_o", clk_en_o, 1);
      @(negedge clk);
    end
  endtask

  // Running at code 127 (period 2); a new code must be refused
  task automatic t_hold();
    int pulses = 0;
    reg_write(8'h80 | 8'd127);
    reg_write(8'h80 | 8'd55);
    check("R4 rd_data", rd_data, 128 + 127);
    for (int i = 0; i < 10; i++) begin
      pulses += int'(clk_en_o);
      @(negedge clk);
    end
    check("R4 pulse count", pulses, 5);
  endtask

  // Data without strobe must change nothing
  task automatic t_idle(input int exp_rd, input int exp_en);
    @(negedge clk);
    wr_data = 8'hFF;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R9 rd_data", rd_data, exp_rd);
      if (exp_en >= 0) check("R9 clk_en_o", clk_en_o, exp_en);
    end
    wr_data = 8'h00;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle(0, 1);
    t_enable(0);
    t_disable(0);
    t_enable(127);
    t_disable(127);
    t_enable(100);
    t_disable(100);
    t_enable(126);
    t_disable(126);
    t_idle(126, 1);
    t_hold();
    t_disable(127);
    t_enable(64);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule